// File: doc/BRIEF.md
# Reloading Down-Counter Timer

This block is a 16-bit timer that counts downward and refills itself from a reload register every time it passes through zero. Counting steps come either from an internal 12-bit power-of-two prescaler running off the system clock, or, in event mode, from rising edges on an external input brought into the clock domain through a register chain. The block can therefore serve as an interval timer, an event counter or a clock divider.

Each pass through zero does three things. It raises a sticky interrupt flag, which software may also set or clear. It drives a one-cycle trigger pulse for neighbouring logic. It toggles a square-wave output, so that output runs at half the zero-event rate. Software reaches the block through a small synchronous bus with four word registers. A write to the control register with the restart bit set loads the count from the reload register and clears the prescaler.

Top module: `reload_timer`

## Requirements
- R1: While reset is held, and on the first cycle after it is released, `irq`, `trig` and `clk_out` are low, and the control, reload, count and flag registers all read zero.
- R2: A control write with bit 3 (restart) set copies the reload register into the count and clears the prescaler on that clock edge. This happens whether or not the timer is running, and restart takes priority over a tick on the same edge.
- R3: In prescaler mode, control bits 7:4 hold a select value n, and a running timer ticks once every 2^n clocks after a restart. Any value of n above 11 acts as 11.
- R4: Each tick lowers a nonzero count by one. A tick that finds the count at zero loads the reload value instead and counts as a zero event, so zero events arrive every reload+1 ticks.
- R5: `trig` is high for exactly the clock cycle that follows each zero-event edge and is low at all other times.
- R6: The register at address 3 holds the interrupt flag in bit 0, which drives `irq`. A zero event sets the flag. Writing 1 to bit 0 sets it, and writing 1 to bit 1 clears it. A zero event wins over a clear on the same edge.
- R7: An internal toggle flips on every zero event. `clk_out` follows that toggle only while control bit 2 (output enable) is set, and stays low when the bit is clear.
- R8: With control bit 1 (event mode) set, ticks come only from rising edges of `ext_evt` after a two-register synchronizer, and the prescaler has no effect on the count.
- R9: With control bit 0 (run) clear, the count and the prescaler hold their values.
- R10: The map is: address 0 for control, address 1 for reload, address 2 for count (read only, so writes have no effect) and address 3 for the flag. `bus_rdata` returns the addressed register one clock after the address is presented. Bit 3 of the control register reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register bus |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data for the address of the previous cycle |
| ext_evt | input | 1 | Asynchronous external event input used in event mode |
| irq | output | 1 | Sticky interrupt flag |
| trig | output | 1 | One-cycle pulse per zero event |
| clk_out | output | 1 | Divided clock, toggling on each zero event when enabled |

## Verification
The bench aims at several corner cases, each of which a faulty design would reveal.

- **Reload of zero with the fastest prescaler.** This must produce a zero event on every tick. A design that decrements before it tests for zero would wrap to 0xFFFF instead.
- **Select values above eleven.** These must behave like eleven. A design that does not clamp them would stall the prescaler or tick at the wrong rate.
- **Writes to the count address.** These must leave the count untouched.
- **Clearing run.** This must freeze the count exactly, so a design that kept ticking would show a drifting count on readback.
- **Event mode.** The count must drop once per external rising edge, whatever the prescaler is doing.
- **Flag clear at the same time as a zero event.** The event must leave the flag set.

// File: rtl/timer_pkg.sv
package timer_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned SEL_W  = 4;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_RELOAD = 2'd1,
    REG_COUNT  = 2'd2,
    REG_FLAG   = 2'd3
  } reg_addr_e;

  // control word bit positions
  localparam int unsigned CTL_RUN     = 0;
  localparam int unsigned CTL_EVT     = 1;
  localparam int unsigned CTL_OUT     = 2;
  localparam int unsigned CTL_RESTART = 3;
  localparam int unsigned CTL_SEL_LSB = 4;

  // flag word bit positions
  localparam int unsigned FLG_SET = 0;
  localparam int unsigned FLG_CLR = 1;

  typedef struct packed {
    logic [SEL_W-1:0] sel;
    logic             clk_en;
    logic             evt_mode;
    logic             run;
  } ctrl_t;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [CNT_W-1:0]  count,
  input  logic              zero_evt,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              restart,
  output logic              flag
);
  logic              wr_ctrl, wr_reload, wr_flag;
  logic              flag_d;
  logic [DATA_W-1:0] rd_mux;

  assign wr_ctrl   = we && (reg_addr_e'(addr) == REG_CTRL);
  assign wr_reload = we && (reg_addr_e'(addr) == REG_RELOAD);
  assign wr_flag   = we && (reg_addr_e'(addr) == REG_FLAG);
  assign restart   = wr_ctrl && wdata[CTL_RESTART];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0;
    end else if (wr_ctrl) begin
      ctrl.sel      <= wdata[CTL_SEL_LSB +: SEL_W];
      ctrl.clk_en   <= wdata[CTL_OUT];
      ctrl.evt_mode <= wdata[CTL_EVT];
      ctrl.run      <= wdata[CTL_RUN];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)            reload <= '0;
    else if (wr_reload) reload <= wdata[CNT_W-1:0];
  end

  // hardware event has priority over a software clear
  always_comb begin
    flag_d = flag;
    if (wr_flag && wdata[FLG_CLR]) flag_d = 1'b0;
    if (wr_flag && wdata[FLG_SET]) flag_d = 1'b1;
    if (zero_evt)                  flag_d = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) flag <= 1'b0;
    else     flag <= flag_d;
  end

  always_comb begin
    rd_mux = '0;
    case (reg_addr_e'(addr))
      REG_CTRL: begin
        rd_mux[CTL_RUN]                 = ctrl.run;
        rd_mux[CTL_EVT]                 = ctrl.evt_mode;
        rd_mux[CTL_OUT]                 = ctrl.clk_en;
        rd_mux[CTL_SEL_LSB +: SEL_W]    = ctrl.sel;
      end
      REG_RELOAD: rd_mux[CNT_W-1:0] = reload;
      REG_COUNT:  rd_mux[CNT_W-1:0] = count;
      REG_FLAG:   rd_mux[0]         = flag;
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_mux;
  end
endmodule

// File: rtl/tmr_tick.sv
module tmr_tick
  import timer_pkg::*;
#(
  parameter int unsigned PRE_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             evt_mode,
  input  logic [SEL_W-1:0] sel,
  input  logic             restart,
  input  logic             ext_in,
  output logic             tick
);
  localparam int unsigned MAX_SEL = PRE_W - 1;

  logic [PRE_W-1:0]       pre_q;
  logic [PRE_W-1:0]       mask;
  logic [SEL_W-1:0]       eff_sel;
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pre_tick, evt_edge;

  always_comb begin
    eff_sel = (sel > SEL_W'(MAX_SEL)) ? SEL_W'(MAX_SEL) : sel;
    mask    = (PRE_W'(1) << eff_sel) - PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || restart) pre_q <= '0;
    else if (run)       pre_q <= pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], ext_in};
      prev_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign pre_tick = ((pre_q & mask) == mask);
  assign evt_edge = sync_q[SYNC_STAGES-1] && !prev_q;
  assign tick     = run && (evt_mode ? evt_edge : pre_tick);
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart,
  input  logic             tick,
  input  logic [CNT_W-1:0] reload,
  input  logic             clk_en,
  output logic [CNT_W-1:0] count,
  output logic             zero_evt,
  output logic             trig,
  output logic             clk_out
);
  logic tog_q;

  assign zero_evt = tick && !restart && (count == '0);

  always_ff @(posedge clk) begin
    if (rst)           count <= '0;
    else if (restart)  count <= reload;
    else if (zero_evt) count <= reload;
    else if (tick)     count <= count - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tog_q   <= 1'b0;
      trig    <= 1'b0;
      clk_out <= 1'b0;
    end else begin
      tog_q   <= tog_q ^ zero_evt;
      trig    <= zero_evt;
      clk_out <= clk_en && (tog_q ^ zero_evt);
    end
  end
endmodule

// File: rtl/reload_timer.sv
module reload_timer
  import timer_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned PRE_W       = 12,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              ext_evt,
  output logic              irq,
  output logic              trig,
  output logic              clk_out
);
  ctrl_t            ctrl_q;
  logic [CNT_W-1:0] reload_q, count_q;
  logic             restart, tick, zero_evt;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk(clk), .rst(rst), .we(bus_we), .addr(bus_addr), .wdata(bus_wdata),
    .rdata(bus_rdata), .count(count_q), .zero_evt(zero_evt), .ctrl(ctrl_q),
    .reload(reload_q), .restart(restart), .flag(irq)
  );

  tmr_tick #(.PRE_W(PRE_W), .SYNC_STAGES(SYNC_STAGES)) u_tick (
    .clk(clk), .rst(rst), .run(ctrl_q.run), .evt_mode(ctrl_q.evt_mode),
    .sel(ctrl_q.sel), .restart(restart), .ext_in(ext_evt), .tick(tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk(clk), .rst(rst), .restart(restart), .tick(tick), .reload(reload_q),
    .clk_en(ctrl_q.clk_en), .count(count_q), .zero_evt(zero_evt),
    .trig(trig), .clk_out(clk_out)
  );
endmodule

// File: rtl/reload_timer_chk.sv
module reload_timer_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             run,
  input logic             clk_en,
  input logic             restart,
  input logic             tick,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] reload,
  input logic             trig,
  input logic             irq,
  input logic             clk_out
);
  p_restart_loads_r2: assert property (@(posedge clk) disable iff (rst)
    restart |=> count == $past(reload));

  p_zero_reloads_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && count == '0) |=> count == $past(reload));

  p_step_down_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && !restart && count != '0) |=> count == $past(count) - CNT_W'(1));

  p_trig_needs_run_r5: assert property (@(posedge clk) disable iff (rst)
    trig |-> $past(run));

  p_trig_sets_irq_r6: assert property (@(posedge clk) disable iff (rst)
    trig |-> irq);

  p_out_gated_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(clk_en) |-> !clk_out);

  p_frozen_r9: assert property (@(posedge clk) disable iff (rst)
    (!run && !restart) |=> $stable(count));
endmodule

bind reload_timer reload_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .run(ctrl_q.run), .clk_en(ctrl_q.clk_en),
  .restart(restart), .tick(tick), .count(count_q), .reload(reload_q),
  .trig(trig), .irq(irq), .clk_out(clk_out)
);

// File: tb/reload_timer_test.sv
`timescale 1ns/1ps
module reload_timer_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [15:0] wdata = 16'd0;
  logic        ext = 1'b0;
  logic [15:0] rdata;
  logic        irq, trig, clk_out;

  always #2.5 clk = ~clk;

  reload_timer uut (
    .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
    .bus_rdata(rdata), .ext_evt(ext), .irq(irq), .trig(trig), .clk_out(clk_out)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural reference, updated from pre-edge state on every rising edge
  int m_cnt, m_rel, m_pre, m_sel, m_run, m_evt, m_en, m_flag, m_tog;
  int m_out, m_trig, m_rdata, m_raddr, e0, e1, e2;

  always @(posedge clk) begin
    int eff, period, tk, zero, rs, nc, rd, nf;
    if (rst) begin
      m_cnt = 0; m_rel = 0; m_pre = 0; m_sel = 0; m_run = 0; m_evt = 0; m_en = 0;
      m_flag = 0; m_tog = 0; m_out = 0; m_trig = 0; m_rdata = 0; m_raddr = 0;
      e0 = 0; e1 = 0; e2 = 0;
    end else begin
      rs = (we && addr == 2'd0 && wdata[3]) ? 1 : 0;
      eff = (m_sel > 11) ? 11 : m_sel;
      period = 1 << eff;
      tk = 0;
      if (m_run != 0 && m_evt == 0) tk = ((m_pre % period) == period - 1) ? 1 : 0;
      if (m_run != 0 && m_evt != 0) tk = (e1 != 0 && e2 == 0) ? 1 : 0;
      zero = (tk != 0 && rs == 0 && m_cnt == 0) ? 1 : 0;
      case (addr)
        2'd0:    rd = (m_sel << 4) | (m_en << 2) | (m_evt << 1) | m_run;
        2'd1:    rd = m_rel;
        2'd2:    rd = m_cnt;
        default: rd = m_flag;
      endcase
      if (rs != 0)        nc = m_rel;
      else if (zero != 0) nc = m_rel;
      else if (tk != 0)   nc = m_cnt - 1;
      else                nc = m_cnt;
      nf = m_flag;
      if (we && addr == 2'd3 && wdata[1]) nf = 0;
      if (we && addr == 2'd3 && wdata[0]) nf = 1;
      if (zero != 0) nf = 1;
      if (rs != 0) m_pre = 0;
      else if (m_run != 0) m_pre = (m_pre + 1) % 4096;
      m_tog   = m_tog ^ zero;
      m_out   = m_en & m_tog;
      m_trig  = zero;
      m_flag  = nf;
      m_cnt   = nc;
      m_rdata = rd;
      m_raddr = addr;
      if (we && addr == 2'd1) m_rel = wdata;
      if (we && addr == 2'd0) begin
        m_run = wdata[0]; m_evt = wdata[1]; m_en = wdata[2]; m_sel = wdata[7:4];
      end
      e2 = e1; e1 = e0; e0 = ext;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(trig == m_trig[0], "R5 trig", trig, m_trig);
      chk(irq == m_flag[0], "R6 irq", irq, m_flag);
      chk(clk_out == m_out[0], "R7 clk_out", clk_out, m_out);
      chk(rdata == m_rdata[15:0], (m_raddr == 2) ? "R4 count read" : "R10 read",
          rdata, m_rdata);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk); we = 1'b1; addr = a[1:0]; wdata = d[15:0];
    @(negedge clk); we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk); addr = a[1:0];
    @(negedge clk); v = rdata;
  endtask

  task automatic trig_period(output int n);
    n = 0;
    do @(negedge clk); while (!trig);
    do begin @(negedge clk); n++; end while (!trig);
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    summary();
    $finish;
  end

  initial begin
    int v, a, b, n;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!irq && !trig && !clk_out, "R1 outputs after reset", {irq, trig, clk_out}, 0);
    rd(0, v); chk(v == 0, "R1 ctrl", v, 0);
    rd(1, v); chk(v == 0, "R1 reload", v, 0);
    rd(2, v); chk(v == 0, "R1 count", v, 0);

    // R2: restart while stopped loads the count
    wr(1, 100);
    wr(0, 16'h0008);
    rd(2, v); chk(v == 100, "R2 restart load", v, 100);
    // R10: count address is read only
    wr(2, 55);
    rd(2, v); chk(v == 100, "R10 count write ignored", v, 100);
    rd(0, v); chk(v == 0, "R10 restart bit reads zero", v, 0);

    // R9: freeze on run clear
    wr(0, 16'h0009);
    repeat (20) @(negedge clk);
    wr(0, 16'h0000);
    rd(2, a);
    repeat (10) @(negedge clk);
    rd(2, b);
    chk(a == b, "R9 count frozen", b, a);
    chk(a < 100, "R9 count moved while running", a, 99);

    // R3: select 2, reload 3 -> 16 clocks between zero events
    wr(1, 3);
    wr(0, 16'h0029);
    trig_period(n); chk(n == 16, "R3 period sel2", n, 16);
    @(negedge clk); chk(!trig, "R5 single pulse", trig, 0);
    chk(irq, "R6 flag set by zero event", irq, 1);

    // R3: select 15 acts as 11
    wr(1, 0);
    wr(0, 16'h00F9);
    trig_period(n); chk(n == 2048, "R3 select clamp", n, 2048);

    // R7: divided clock, high for one reload interval
    wr(1, 3);
    wr(0, 16'h002D);
    do @(negedge clk); while (!clk_out);
    n = 0;
    do begin @(negedge clk); n++; end while (clk_out);
    chk(n == 16, "R7 clk_out half period", n, 16);
    wr(0, 16'h0021);
    a = 0;
    for (int i = 0; i < 40; i++) begin @(negedge clk); if (clk_out) a++; end
    chk(a == 0, "R7 clk_out low when disabled", a, 0);

    // R4: reload 0 with fastest prescaler -> zero event each tick
    wr(1, 0);
    wr(0, 16'h0009);
    @(negedge clk);
    a = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); if (trig) a++; end
    chk(a == 5, "R4 reload zero every tick", a, 5);

    // R6: software clear and set
    wr(0, 16'h0000);
    wr(3, 2); chk(!irq, "R6 clear", irq, 0);
    wr(3, 1); chk(irq, "R6 set", irq, 1);
    wr(3, 2); chk(!irq, "R6 clear again", irq, 0);

    // R8: event counting
    wr(1, 10);
    wr(0, 16'h000B);
    for (int i = 0; i < 3; i++) begin
      ext = 1'b1; repeat (4) @(negedge clk);
      ext = 1'b0; repeat (4) @(negedge clk);
    end
    repeat (5) @(negedge clk);
    rd(2, v); chk(v == 7, "R8 three edges counted", v, 7);
    repeat (30) @(negedge clk);
    rd(2, v); chk(v == 7, "R8 no prescaler ticks", v, 7);

    summary();
    $finish;
  end
endmodule